// File: doc/BRIEF.md
# Device Key Profile Vault

This block holds per-provider secret profiles on a device and answers authentication challenges from outside. It keeps a bank of `NPROF` secret words and a matching bank of derived key words, one pair per profile index. Both banks are write-once. A secret is loaded once through a load request. After that, a challenge request carries a profile index, an authority response word and an odd modulus. The block mixes the response with the stored secret to form an intermediate secret. It places that intermediate secret above the response to form a double-width value, squares this value modulo the supplied modulus, and returns the result as the token.

During the same challenge the block derives the profile key by mixing the intermediate secret with the response. It stores the key at that index unless a key is already there. The key never appears on a port. Only the squared token and per-profile status flags leave the block.

The mixing function is an iterated compression, one round per clock. The modular squaring is bit-serial: a reduction pass and then a shift-and-add pass, one operand bit per clock. A request is taken only when the block is idle. Each request is answered by a one-cycle `done` pulse, with `err` marking a refused request.

Top module: `devkey_vault`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `token`, `prof_loaded` and `prof_keyed` are all zero.
- R2: A load request (`req_op`=0) to an index whose `prof_loaded` bit is clear stores `req_secret`, sets that bit, and pulses `done` with `err`=0 in the cycle after acceptance.
- R3: A load request to an index that is already loaded is refused: `done` and `err` pulse in the cycle after acceptance, and the stored secret is unchanged. Later tokens for that index still use the first secret.
- R4: A challenge (`req_op`=1) returns `token` = X² mod m. Here X = {I, resp} with I in the upper W bits, I = H(resp, S[idx]), and m = `req_mod`. H(a,b) starts with x=a and y=b and runs `HROUNDS` rounds r=0..HROUNDS-1. Each round computes x = rotl(x+y, 13) ^ (KMIX·(r+1)) and then y = rotl(y, 29) ^ x, all modulo 2^W. The result is x^y, with KMIX = 0x9E3779B97F4A7C15.
- R5: The first successful challenge on an index derives the key H(I, resp), stores it, and sets `prof_keyed[idx]`. Later challenges never overwrite a stored key, and the bit stays set.
- R6: A challenge to an index whose `prof_loaded` bit is clear is refused: `done` and `err` pulse in the cycle after acceptance, while `token` and `prof_keyed` stay unchanged.
- R7: A challenge with an even modulus (including zero) is refused in the same way, with `token` and `prof_keyed` unchanged.
- R8: A valid challenge raises `busy` from the cycle after acceptance. It pulses `done` with `err`=0 exactly 2·HROUNDS + 4·W + 3 cycles after the accepting edge, which is 275 cycles with the defaults.
- R9: Requests presented while `busy` is high, or in the cycle `done` is high, are ignored: no profile is loaded by them.
- R10: `done` is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = load secret, 1 = challenge |
| req_idx | input | $clog2(NPROF) | Profile index |
| req_secret | input | W | Secret word for a load |
| req_resp | input | W | Authority response word for a challenge |
| req_mod | input | 2W | Modulus for the squaring, must be odd |
| busy | output | 1 | Challenge in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with `done` |
| token | output | 2W | Last squared token |
| prof_loaded | output | NPROF | Secret present per profile |
| prof_keyed | output | NPROF | Key derived per profile |

## Verification
Loads and refused requests are answered on the edge that accepts them. The bench samples `done` and `err` at the falling edge right after that edge. A valid challenge passes through two hash runs of `HROUNDS` cycles each, a 2W-cycle reduction and a 2W-cycle squaring, plus three handover registers. The bench therefore counts rising edges after acceptance and requires `done` to appear at exactly edge 2·HROUNDS+4W+3, never earlier. Token, status flags and the following low cycle of `done` are all read at falling edges once `done` is seen, so each value is checked in the cycle it is due.

// File: rtl/dkv_pkg.sv
// Shared types for the device key profile vault.
// Assumes: one-bit request opcode, four-state control sequence.
package dkv_pkg;
    typedef enum logic {
        OP_LOAD = 1'b0,
        OP_CHAL = 1'b1
    } dkv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HASH_I = 2'd1,
        ST_HASH_K = 2'd2,
        ST_SQUARE = 2'd3
    } dkv_state_e;
endpackage

// File: rtl/dkv_mix_hash.sv
// Iterated compression of two W-bit words, one round per clock.
// start loads (a,b). ROUNDS rounds follow, then fin pulses for one cycle
// and digest holds x^y until the next start.
// Assumes: start is not raised while a run is in progress.
module dkv_mix_hash #(
    parameter int unsigned W      = 64,
    parameter int unsigned ROUNDS = 8,
    parameter int unsigned RA     = 13,
    parameter int unsigned RB     = 29,
    parameter logic [W-1:0] KMIX  = 64'h9E3779B97F4A7C15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         fin,
    output logic [W-1:0] digest
);
    localparam int unsigned CW = $clog2(ROUNDS + 1);
    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    logic [W-1:0]  x_q, y_q, sum, rc, x_n, y_n;
    logic [CW-1:0] rnd_q;
    logic          run_q;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int unsigned n);
        return (v << n) | (v >> (W - n));
    endfunction

    // One round of the mix applied to the current state
    always_comb begin
        sum = x_q + y_q;
        rc  = KMIX * (W'(rnd_q) + W'(1));
        x_n = rotl(sum, RA) ^ rc;
        y_n = rotl(y_q, RB) ^ x_n;
    end

    assign digest = x_q ^ y_q;

    // Load on start, step rounds while running, flag the final round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            rnd_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                x_q   <= a;
                y_q   <= b;
                rnd_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                x_q   <= x_n;
                y_q   <= y_n;
                rnd_q <= rnd_q + 1'b1;
                if (rnd_q == LAST) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    // R8
    hash_fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !run_q);
endmodule

// File: rtl/dkv_modsq.sv
// Bit-serial modular squaring: res = xin^2 mod mod.
// Pass 1 reduces xin modulo mod, one bit per clock (XW clocks).
// Pass 2 runs a shift-and-add multiply of xin by the reduced value,
// one bit per clock (XW clocks). fin pulses when res is written.
// Assumes: mod is nonzero when start is raised, and there is no start during a run.
module dkv_modsq #(
    parameter int unsigned XW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] xin,
    input  logic [XW-1:0] mod,
    output logic          fin,
    output logic [XW-1:0] res
);
    localparam int unsigned CW = $clog2(XW);
    localparam logic [CW-1:0] LAST = CW'(XW - 1);

    logic [XW-1:0] x_keep, xs, m_q, acc, a_q;
    logic [CW-1:0] cnt;
    logic          phase, run_q;
    logic [XW:0]   red_t, red_n, dbl, dbl_r, sm, sm_r, m_ext;
    logic          bit_in;

    assign bit_in = xs[XW-1];
    assign m_ext  = {1'b0, m_q};

    // Reduction step (pass 1) and double-then-add step (pass 2)
    always_comb begin
        red_t = {acc, bit_in};
        red_n = (red_t >= m_ext) ? red_t - m_ext : red_t;
        dbl   = {acc, 1'b0};
        dbl_r = (dbl >= m_ext) ? dbl - m_ext : dbl;
        sm    = dbl_r + (bit_in ? {1'b0, a_q} : '0);
        sm_r  = (sm >= m_ext) ? sm - m_ext : sm;
    end

    // Sequence the two passes and capture the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_keep <= '0;
            xs     <= '0;
            m_q    <= '0;
            acc    <= '0;
            a_q    <= '0;
            cnt    <= '0;
            phase  <= 1'b0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
            res    <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                x_keep <= xin;
                xs     <= xin;
                m_q    <= mod;
                acc    <= '0;
                cnt    <= '0;
                phase  <= 1'b0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                xs  <= xs << 1;
                cnt <= cnt + 1'b1;
                if (!phase) begin
                    acc <= red_n[XW-1:0];
                    if (cnt == LAST) begin
                        a_q   <= red_n[XW-1:0];
                        acc   <= '0;
                        xs    <= x_keep;
                        phase <= 1'b1;
                    end
                end else begin
                    acc <= sm_r[XW-1:0];
                    if (cnt == LAST) begin
                        res   <= sm_r[XW-1:0];
                        fin   <= 1'b1;
                        run_q <= 1'b0;
                    end
                end
            end
        end
    end

    // R4
    res_lt_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (res < m_q));
    // R4
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start) |-> (acc < m_q));
endmodule

// File: rtl/dkv_profile_bank.sv
// Write-once storage for NPROF secret words and NPROF key words.
// A write to an entry whose valid bit is set is dropped.
// Secrets are read combinationally. Keys have no read port.
// Assumes: NPROF is a power of two.
module dkv_profile_bank #(
    parameter int unsigned W     = 64,
    parameter int unsigned NPROF = 4,
    localparam int unsigned IDXW = $clog2(NPROF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s_we,
    input  logic [IDXW-1:0] s_idx,
    input  logic [W-1:0]    s_wdata,
    input  logic [IDXW-1:0] s_ridx,
    output logic [W-1:0]    s_rdata,
    input  logic            k_we,
    input  logic [IDXW-1:0] k_idx,
    input  logic [W-1:0]    k_wdata,
    output logic [NPROF-1:0] s_valid,
    output logic [NPROF-1:0] k_valid
);
    logic [W-1:0] smem [NPROF];
    logic [W-1:0] kmem [NPROF];

    assign s_rdata = smem[s_ridx];

    // Commit a write only into an entry not yet written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= '0;
            k_valid <= '0;
            for (int i = 0; i < NPROF; i++) begin
                smem[i] <= '0;
                kmem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NPROF; i++) begin
                if (s_we && (s_idx == IDXW'(i)) && !s_valid[i]) begin
                    smem[i]    <= s_wdata;
                    s_valid[i] <= 1'b1;
                end
                if (k_we && (k_idx == IDXW'(i)) && !k_valid[i]) begin
                    kmem[i]    <= k_wdata;
                    k_valid[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar gi = 0; gi < NPROF; gi++) begin : g_once
        // R3
        s_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[gi] |=> (s_valid[gi] && $stable(smem[gi])));
        // R5
        k_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            k_valid[gi] |=> (k_valid[gi] && $stable(kmem[gi])));
    end
endmodule

// File: rtl/devkey_vault.sv
// Device key profile vault, top level.
// Loads write-once secrets. A challenge computes I = H(resp, S[idx]),
// stores K[idx] = H(I, resp) once, and returns ({I,resp})^2 mod m.
// The key stays internal. Refused requests answer with done+err at once.
// Assumes: requests are single-cycle pulses and NPROF is a power of two >= 2.
module devkey_vault
    import dkv_pkg::*;
#(
    parameter int unsigned W       = 64,
    parameter int unsigned NPROF   = 4,
    parameter int unsigned HROUNDS = 8,
    parameter int unsigned ROT_A   = 13,
    parameter int unsigned ROT_B   = 29,
    parameter logic [W-1:0] KMIX   = 64'h9E3779B97F4A7C15,
    localparam int unsigned IDXW   = $clog2(NPROF),
    localparam int unsigned TW     = 2 * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [IDXW-1:0]  req_idx,
    input  logic [W-1:0]     req_secret,
    input  logic [W-1:0]     req_resp,
    input  logic [TW-1:0]    req_mod,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [TW-1:0]    token,
    output logic [NPROF-1:0] prof_loaded,
    output logic [NPROF-1:0] prof_keyed
);
    dkv_state_e      state;
    dkv_op_e         op;
    logic [IDXW-1:0] idx_q;
    logic [W-1:0]    resp_q, inter_q, s_rdata, h_a, h_b, h_digest;
    logic [TW-1:0]   mod_q, ms_res;
    logic            accept, load_ok, chal_ok, refuse;
    logic            h_start, h_fin, ms_start, ms_fin;

    assign op      = dkv_op_e'(req_op);
    assign accept  = req_valid && (state == ST_IDLE) && !done;
    assign load_ok = accept && (op == OP_LOAD) && !prof_loaded[req_idx];
    assign chal_ok = accept && (op == OP_CHAL) && prof_loaded[req_idx] && req_mod[0];
    assign refuse  = accept && !load_ok && !chal_ok;
    assign busy    = (state != ST_IDLE);

    // Select the hash operands for the intermediate or the key run
    always_comb begin
        if (state == ST_IDLE) begin
            h_a = req_resp;
            h_b = s_rdata;
        end else begin
            h_a = h_digest;
            h_b = resp_q;
        end
    end

    assign h_start  = chal_ok || ((state == ST_HASH_I) && h_fin);
    assign ms_start = (state == ST_HASH_K) && h_fin;

    dkv_profile_bank #(.W(W), .NPROF(NPROF)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_we    (load_ok),
        .s_idx   (req_idx),
        .s_wdata (req_secret),
        .s_ridx  (req_idx),
        .s_rdata (s_rdata),
        .k_we    (ms_start),
        .k_idx   (idx_q),
        .k_wdata (h_digest),
        .s_valid (prof_loaded),
        .k_valid (prof_keyed)
    );

    dkv_mix_hash #(.W(W), .ROUNDS(HROUNDS), .RA(ROT_A), .RB(ROT_B), .KMIX(KMIX)) u_hash (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (h_start),
        .a      (h_a),
        .b      (h_b),
        .fin    (h_fin),
        .digest (h_digest)
    );

    dkv_modsq #(.XW(TW)) u_sq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ms_start),
        .xin   ({inter_q, resp_q}),
        .mod   (mod_q),
        .fin   (ms_fin),
        .res   (ms_res)
    );

    // Challenge sequencing and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            resp_q  <= '0;
            mod_q   <= '0;
            inter_q <= '0;
            token   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (chal_ok) begin
                    idx_q  <= req_idx;
                    resp_q <= req_resp;
                    mod_q  <= req_mod;
                    state  <= ST_HASH_I;
                end
                ST_HASH_I: if (h_fin) begin
                    inter_q <= h_digest;
                    state   <= ST_HASH_K;
                end
                ST_HASH_K: if (h_fin) state <= ST_SQUARE;
                ST_SQUARE: if (ms_fin) begin
                    token <= ms_res;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion and refusal pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= load_ok || refuse || ((state == ST_SQUARE) && ms_fin);
            err  <= refuse;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prof_loaded));
    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R7
    refuse_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(token) && $stable(prof_keyed)));
endmodule

// File: tb/devkey_vault_test.sv
module devkey_vault_test;
    localparam int W = 64;
    localparam int NP = 4;
    localparam int HR = 8;
    localparam int TW = 128;
    localparam int LAT = 2 * HR + 4 * W + 3;
    localparam logic [63:0] KM = 64'h9E3779B97F4A7C15;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_op;
    logic [1:0] req_idx;
    logic [W-1:0] req_secret, req_resp;
    logic [TW-1:0] req_mod;
    logic busy, done, err;
    logic [TW-1:0] token;
    logic [NP-1:0] prof_loaded, prof_keyed;

    int nchk = 0;
    int nerr = 0;
    int lat;
    logic busy0;
    logic [W-1:0] sec [NP];
    logic [TW-1:0] mods [4];

    always #5 clk = ~clk;

    devkey_vault uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_secret(req_secret), .req_resp(req_resp),
        .req_mod(req_mod), .busy(busy), .done(done), .err(err), .token(token),
        .prof_loaded(prof_loaded), .prof_keyed(prof_keyed)
    );

    function automatic logic [63:0] rl(input logic [63:0] v, input int n);
        return (v << n) | (v >> (64 - n));
    endfunction

    function automatic logic [63:0] bh(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] x, y;
        x = a;
        y = b;
        for (int r = 0; r < HR; r++) begin
            x = rl(x + y, 13) ^ (KM * 64'(r + 1));
            y = rl(y, 29) ^ x;
        end
        return x ^ y;
    endfunction

    function automatic logic [127:0] model_tok(input logic [63:0] s, input logic [63:0] resp,
                                              input logic [127:0] m);
        logic [127:0] xv;
        logic [255:0] p, q;
        xv = {bh(resp, s), resp};
        p  = {128'b0, xv} * {128'b0, xv};
        q  = p % {128'b0, m};
        return q[127:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request, wait for done; lat counts rising edges after acceptance.
    // With inject set, a load to index 3 is offered while the block is busy.
    task automatic issue(input logic op, input logic [1:0] idx, input logic [63:0] s,
                         input logic [63:0] resp, input logic [127:0] m, input bit inject);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_idx    = idx;
        req_secret = s;
        req_resp   = resp;
        req_mod    = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy0 = busy;
        lat = 0;
        while (!done && lat < 2000) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (inject && lat == 5) begin
                req_valid  = 1'b1;
                req_op     = 1'b0;
                req_idx    = 2'd3;
                req_secret = 64'hDEAD;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    task automatic chal_ok(input int idx, input logic [63:0] resp, input logic [127:0] m,
                           input bit inject);
        logic [127:0] exp;
        exp = model_tok(sec[idx], resp, m);
        issue(1'b1, 2'(idx), 64'h0, resp, m, inject);
        chk(lat == LAT && busy0, "R8 latency", 128'(lat), 128'(LAT));
        chk(err == 1'b0, "R8 err", 128'(err), 128'd0);
        // R4 token, R3 first secret still in use
        chk(token == exp, "R4 token", token, exp);
        chk(prof_keyed[idx], "R5 keyed", 128'(prof_keyed), 128'(1 << idx));
        @(negedge clk);
        chk(!done, "R10 done pulse", 128'(done), 128'd0);
    endtask

    initial begin
        #(200000 * 10);
        nchk++;
        nerr++;
        $display("FAIL watchdog R8 actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [127:0] tk;
        logic [NP-1:0] kd;
        sec[0] = 64'h0123456789ABCDEF;
        sec[1] = 64'hFEDCBA9876543210;
        sec[2] = 64'h0F0F00FF12345678;
        sec[3] = 64'hA5A55A5AC3C33C3C;
        mods[0] = 128'hF1234567_89ABCDEF_0FEDCBA9_87654321;
        mods[1] = 128'h00000000_00000001_00000000_00000061;
        mods[2] = 128'd97;
        mods[3] = 128'd1;
        req_valid = 1'b0; req_op = 1'b0; req_idx = '0;
        req_secret = '0; req_resp = '0; req_mod = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err, "R1 ctrl", {busy, done, err}, 128'd0);
        chk(token == 0 && prof_loaded == 0 && prof_keyed == 0, "R1 state",
            {token[63:0], 56'd0, prof_loaded, prof_keyed}, 128'd0);

        // R6 challenge on an unloaded index
        issue(1'b1, 2'd2, 64'h0, 64'h1111, mods[0], 1'b0);
        chk(lat == 0 && err && token == 0 && prof_keyed == 0, "R6 refuse",
            {96'(lat), 28'd0, prof_keyed}, 128'd0);

        // R2 load three profiles
        for (int i = 0; i < 3; i++) begin
            issue(1'b0, 2'(i), sec[i], 64'h0, 128'h0, 1'b0);
            chk(lat == 0 && !err && prof_loaded[i], "R2 load",
                {96'(lat), 27'd0, err, prof_loaded}, 128'(1 << i));
        end

        // R9 load to index 3 offered while busy must be ignored
        chal_ok(0, 64'h5555AAAA0000FFFF, mods[0], 1'b1);
        chk(prof_loaded[3] == 1'b0, "R9 busy ignore", 128'(prof_loaded), 128'h7);

        issue(1'b0, 2'd3, sec[3], 64'h0, 128'h0, 1'b0);
        chk(lat == 0 && !err && prof_loaded == 4'hF, "R2 load3", 128'(prof_loaded), 128'hF);

        // R3 reload refused
        issue(1'b0, 2'd1, 64'h9999999999999999, 64'h0, 128'h0, 1'b0);
        chk(lat == 0 && err, "R3 reload", 128'(err), 128'd1);

        // Sweep every profile against each odd modulus (R4, R5, R8)
        for (int i = 0; i < NP; i++) begin
            for (int j = 0; j < 4; j++) begin
                chal_ok(i, {32'(i * 7 + 3), 32'(j * 1000003 + 17)} ^ 64'hC0FFEE00_12345678,
                        mods[j], 1'b0);
            end
        end
        chk(prof_keyed == 4'hF, "R5 all keyed", 128'(prof_keyed), 128'hF);

        // R7 even and zero moduli refused, token and key flags untouched
        tk = token;
        kd = prof_keyed;
        issue(1'b1, 2'd1, 64'h0, 64'h2222, mods[0] ^ 128'd1, 1'b0);
        chk(lat == 0 && err && token == tk && prof_keyed == kd, "R7 even", token, tk);
        issue(1'b1, 2'd1, 64'h0, 64'h2222, 128'd0, 1'b0);
        chk(lat == 0 && err && token == tk && prof_keyed == kd, "R7 zero", token, tk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule